// File: doc/BRIEF.md
# LED Pixel Word Buffer with Refill Requests

This block sits between a register bus and a serial LED waveform encoder. Software or a DMA engine writes 32-bit pixel words into a small first-in first-out buffer through a data register. The encoder drains the buffer through a valid/ready pixel port. A programmable fill threshold decides when more words are wanted. In DMA mode that need drives a request line. Otherwise it latches a CPU-request status flag that can raise an interrupt.

A transfer starts with a write to the start register. That write empties the buffer and loads the number of words that are still to be supplied. Each word the buffer accepts lowers that count, so requests stop once the whole frame has been written. The encoder pulses a finish input when it has sent the frame. The finish pulse latches a second status flag. Both flags are cleared by writing one to them. The status word also shows the live fill level. One interrupt line combines the flags through per-source enables and a global enable.

Top module: `led_pix_fifo`

## Requirements
- R1: After reset the buffer is empty, pix_valid_o, dma_req_o and irq_o are low, and the status (0x0C), DMA control (0x04) and interrupt control (0x08) registers read zero.
- R2: A write to the data address 0x00 pushes one word. Words leave pix_data_o in write order while pix_valid_o is high, one per cycle in which pix_ready_i is high. Status bits 15:10 show the current fill level.
- R3: A data write to a full buffer is dropped and the level stays at DEPTH. A read of the data address returns zero.
- R4: A write to the start address 0x10 empties the buffer and loads the remaining-word count from its low LEN_W bits. Each accepted data write lowers the count by one, and the count does not go below zero.
- R5: The refill condition holds when the fill level is at or below the effective threshold and the remaining count is non-zero.
- R6: With the DMA enable (DMA control bit 5) set, dma_req_o follows the refill condition and the CPU-request flag is never set. In this mode the effective threshold is the trigger field (DMA control bits TRIG_W-1:0), raised to DEPTH/2 when it is lower.
- R7: With the DMA enable clear, dma_req_o stays low and the CPU-request flag (status bit 1) is set on every cycle in which the refill condition holds. The threshold is the trigger field as written.
- R8: A finish_i pulse sets the transfer-finish flag (status bit 0) on the next cycle. A set on the same cycle as a clear wins, and this applies to both flags.
- R9: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.
- R10: irq_o is high when interrupt control bit 5 is set and at least one flag is set together with its enable: bit 0 for the finish flag, bit 1 for the CPU-request flag.
- R11: The control registers read back only their implemented bits: DMA control bits 5 and TRIG_W-1:0, and interrupt control bits 5, 1 and 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| pix_valid_o | output | 1 | Buffer holds a word |
| pix_ready_i | input | 1 | Encoder takes the word this cycle |
| pix_data_o | output | 32 | Oldest buffered word |
| finish_i | input | 1 | Encoder has finished the frame |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 1 | DMA refill request |

## Verification
The bench builds the block with DEPTH=8 and LEN_W=8. This gives a 3-bit trigger field and a DMA floor of 4. With these values a handful of writes fills the buffer, so the dropped-write case is easy to reach. A trigger of 2 can also be set in DMA mode, and the request must then still be raised at level 4, which shows the floor at work. A frame length of 6 lets the remaining count run out while the buffer is below threshold, so the test confirms the request drops on that count alone.

// File: rtl/led_fifo_pkg.sv
package led_fifo_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_DATA   = 5'h00;
  localparam logic [ADDR_W-1:0] A_DMA    = 5'h04;
  localparam logic [ADDR_W-1:0] A_INT    = 5'h08;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h0C;
  localparam logic [ADDR_W-1:0] A_START  = 5'h10;

  localparam int unsigned B_DMA_EN  = 5;
  localparam int unsigned B_GLB_EN  = 5;
  localparam int unsigned B_CPU     = 1;
  localparam int unsigned B_FIN     = 0;
  localparam int unsigned LVL_LSB   = 10;
  localparam int unsigned LVL_FIELD = 6;

  typedef struct packed {
    logic glb;
    logic cpu;
    logic fin;
  } irq_en_t;
endpackage

// File: rtl/pix_buf.sv
module pix_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             accept_o,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic [LW-1:0]    level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [LW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign valid_o  = (cnt_q != '0);
  assign accept_o = push_i && (cnt_q != LW'(DEPTH));
  assign do_push  = accept_o && !flush_i;
  assign do_pop   = pop_i && valid_o && !flush_i;
  assign rdata_o  = mem_q[rp_q];
  assign level_o  = cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wrap_inc(wp_q);
      if (do_pop)  rp_q <= wrap_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/refill_req.sv
module refill_req #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned TRIG_W = 5,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0]     level_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              dma_en_i,
  input  logic              work_left_i,
  output logic              cond_o,
  output logic              dma_req_o,
  output logic              cpu_set_o
);
  localparam int unsigned FLOOR = DEPTH / 2;

  logic [LW-1:0] thr;

  always_comb begin
    thr = LW'(trig_i);
    if (dma_en_i && (thr < LW'(FLOOR))) thr = LW'(FLOOR);
  end

  assign cond_o    = work_left_i && (level_i <= thr);
  assign dma_req_o = cond_o && dma_en_i;
  assign cpu_set_o = cond_o && !dma_en_i;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import led_fifo_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fin_set_i,
  input  logic    cpu_set_i,
  input  logic    clr_we_i,
  input  logic    fin_clr_i,
  input  logic    cpu_clr_i,
  input  irq_en_t en_i,
  output logic    fin_o,
  output logic    cpu_o,
  output logic    irq_o
);
  logic fin_q, cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      // set has priority over a same-cycle clear
      if (fin_set_i)                  fin_q <= 1'b1;
      else if (clr_we_i && fin_clr_i) fin_q <= 1'b0;
      if (cpu_set_i)                  cpu_q <= 1'b1;
      else if (clr_we_i && cpu_clr_i) cpu_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
  assign cpu_o = cpu_q;
  assign irq_o = en_i.glb && ((fin_q && en_i.fin) || (cpu_q && en_i.cpu));
endmodule

// File: rtl/led_pix_fifo.sv
module led_pix_fifo
  import led_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [DATA_W-1:0] pix_data_o,
  input  logic              finish_i,
  output logic              irq_o,
  output logic              dma_req_o
);
  localparam int unsigned TRIG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW     = $clog2(DEPTH + 1);

  logic              we_data, we_dma, we_int, we_stat, we_start;
  logic              dma_en_q;
  logic [TRIG_W-1:0] trig_q;
  irq_en_t           ien_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LW-1:0]     level;
  logic              accepted, req_cond, cpu_set, flag_fin, flag_cpu;

  assign we_data  = reg_we_i && (reg_addr_i == A_DATA);
  assign we_dma   = reg_we_i && (reg_addr_i == A_DMA);
  assign we_int   = reg_we_i && (reg_addr_i == A_INT);
  assign we_stat  = reg_we_i && (reg_addr_i == A_STATUS);
  assign we_start = reg_we_i && (reg_addr_i == A_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q <= 1'b0;
      trig_q   <= '0;
      ien_q    <= '0;
      rem_q    <= '0;
    end else begin
      if (we_dma) begin
        dma_en_q <= reg_wdata_i[B_DMA_EN];
        trig_q   <= reg_wdata_i[TRIG_W-1:0];
      end
      if (we_int) begin
        ien_q.glb <= reg_wdata_i[B_GLB_EN];
        ien_q.cpu <= reg_wdata_i[B_CPU];
        ien_q.fin <= reg_wdata_i[B_FIN];
      end
      if (we_start)                        rem_q <= reg_wdata_i[LEN_W-1:0];
      else if (accepted && rem_q != '0)    rem_q <= rem_q - 1'b1;
    end
  end

  pix_buf #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (we_start),
    .push_i   (we_data),
    .wdata_i  (reg_wdata_i),
    .accept_o (accepted),
    .pop_i    (pix_ready_i),
    .valid_o  (pix_valid_o),
    .rdata_o  (pix_data_o),
    .level_o  (level)
  );

  refill_req #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_req (
    .level_i     (level),
    .trig_i      (trig_q),
    .dma_en_i    (dma_en_q),
    .work_left_i (rem_q != '0),
    .cond_o      (req_cond),
    .dma_req_o   (dma_req_o),
    .cpu_set_o   (cpu_set)
  );

  irq_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fin_set_i (finish_i),
    .cpu_set_i (cpu_set),
    .clr_we_i  (we_stat),
    .fin_clr_i (reg_wdata_i[B_FIN]),
    .cpu_clr_i (reg_wdata_i[B_CPU]),
    .en_i      (ien_q),
    .fin_o     (flag_fin),
    .cpu_o     (flag_cpu),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DMA: begin
        reg_rdata_o[B_DMA_EN]   = dma_en_q;
        reg_rdata_o[TRIG_W-1:0] = trig_q;
      end
      A_INT: begin
        reg_rdata_o[B_GLB_EN] = ien_q.glb;
        reg_rdata_o[B_CPU]    = ien_q.cpu;
        reg_rdata_o[B_FIN]    = ien_q.fin;
      end
      A_STATUS: begin
        reg_rdata_o[B_FIN]           = flag_fin;
        reg_rdata_o[B_CPU]           = flag_cpu;
        reg_rdata_o[LVL_LSB +: LW]   = level;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/led_pix_fifo_chk.sv
module led_pix_fifo_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 13,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LW-1:0]    level,
  input logic             pix_valid_o,
  input logic             pix_ready_i,
  input logic             we_start,
  input logic             dma_req_o,
  input logic [LEN_W-1:0] rem_q,
  input logic             dma_en_q,
  input logic             flag_cpu,
  input logic             flag_fin,
  input logic             finish_i,
  input logic             we_stat,
  input logic [31:0]      reg_wdata_i,
  input logic             req_cond,
  input logic             irq_o,
  input logic [31:0]      reg_rdata_o
);
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LW'(DEPTH)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level == LW'(DEPTH) && !pix_ready_i && !we_start) |=> level == LW'(DEPTH)); // R3
  AST_REQ_NEEDS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> rem_q != '0); // R5
  AST_DMA_NO_CPU_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_q && !flag_cpu) |=> !flag_cpu); // R6
  AST_CPU_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_q |-> !dma_req_o); // R7
  AST_FINISH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |=> flag_fin); // R8
  AST_W1C_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_stat && reg_wdata_i[1] && !(req_cond && !dma_en_q)) |=> !flag_cpu); // R9
  AST_VALID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o == (level != '0)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_fin || flag_cpu)); // R10
  AST_NO_X_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(reg_rdata_o)); // R11
endmodule

bind led_pix_fifo led_pix_fifo_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .level       (level),
  .pix_valid_o (pix_valid_o),
  .pix_ready_i (pix_ready_i),
  .we_start    (we_start),
  .dma_req_o   (dma_req_o),
  .rem_q       (rem_q),
  .dma_en_q    (dma_en_q),
  .flag_cpu    (flag_cpu),
  .flag_fin    (flag_fin),
  .finish_i    (finish_i),
  .we_stat     (we_stat),
  .reg_wdata_i (reg_wdata_i),
  .req_cond    (req_cond),
  .irq_o       (irq_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/led_pix_fifo_test.sv
module led_pix_fifo_test;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned LEN_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pv, pready = 1'b0;
  logic [31:0] pdata;
  logic        fin = 1'b0;
  logic        irq, dreq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_pix_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pix_valid_o(pv),
    .pix_ready_i(pready), .pix_data_o(pdata), .finish_i(fin),
    .irq_o(irq), .dma_req_o(dreq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    chk({tag, " valid"}, {31'b0, pv}, 32'd1);
    chk({tag, " data"}, pdata, exp);
    pready = 1'b1;
    @(negedge clk);
    pready = 1'b0;
  endtask

  function automatic logic [31:0] lvl(input logic [31:0] s);
    return (s >> 10) & 32'h3F;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pix_valid", {31'b0, pv}, 0);
    chk("R1 dma_req", {31'b0, dreq}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(5'h0C, v); chk("R1 status", v, 0);
    rd(5'h04, v); chk("R1 dma ctrl", v, 0);
    rd(5'h08, v); chk("R1 int ctrl", v, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    wr(5'h10, 20);
    for (int i = 0; i < 3; i++) wr(5'h00, 32'hA000_0000 + i);
    rd(5'h0C, v); chk("R2 level 3", lvl(v), 3);
    rd(5'h00, v); chk("R3 data read zero", v, 0);
    for (int i = 0; i < 3; i++) pop_chk("R2 order", 32'hA000_0000 + i);
    chk("R2 empty", {31'b0, pv}, 0);
    rd(5'h0C, v); chk("R2 level 0", lvl(v), 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    wr(5'h10, 20);
    for (int i = 0; i < 10; i++) wr(5'h00, 32'hB000_0000 + i);
    rd(5'h0C, v); chk("R3 level full", lvl(v), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_chk("R3 kept words", 32'hB000_0000 + i);
    chk("R3 dropped words absent", {31'b0, pv}, 0);
    // R4: start flushes a partly filled buffer
    wr(5'h00, 32'hC0DE);
    wr(5'h10, 5);
    rd(5'h0C, v); chk("R4 flush on start", lvl(v), 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(5'h04, 32'h22);
    wr(5'h10, 6);
    wr(5'h0C, 3);
    rd(5'h0C, v); chk("R6 cpu flag clear in dma mode", v & 3, 0);
    chk("R6 dma_req empty", {31'b0, dreq}, 1);
    for (int i = 0; i < 4; i++) wr(5'h00, i);
    chk("R6 floor keeps request at level 4", {31'b0, dreq}, 1);
    wr(5'h00, 4);
    chk("R5 above threshold", {31'b0, dreq}, 0);
    pop_chk("R2 dma pop", 0);
    chk("R5 back at threshold", {31'b0, dreq}, 1);
    wr(5'h00, 5);
    chk("R4 count exhausted", {31'b0, dreq}, 0);
    pop_chk("R2 dma pop", 1);
    pop_chk("R2 dma pop", 2);
    chk("R5 no work left", {31'b0, dreq}, 0);
    rd(5'h0C, v); chk("R6 cpu flag never set", v & 2, 0);
  endtask

  task automatic t_cpu();
    logic [31:0] v;
    wr(5'h04, 32'h03);
    wr(5'h10, 4);
    step();
    rd(5'h0C, v); chk("R7 cpu flag set", v & 2, 2);
    chk("R7 no dma_req", {31'b0, dreq}, 0);
    wr(5'h0C, 2);
    rd(5'h0C, v); chk("R8 set wins over clear", v & 2, 2);
    wr(5'h08, 32'h22);
    chk("R10 irq cpu", {31'b0, irq}, 1);
    for (int i = 0; i < 4; i++) wr(5'h00, 32'hD0 + i);
    wr(5'h0C, 2);
    rd(5'h0C, v); chk("R9 cpu flag cleared", v & 3, 0);
    chk("R10 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_finish();
    logic [31:0] v;
    @(negedge clk); fin = 1'b1;
    @(negedge clk); fin = 1'b0;
    rd(5'h0C, v); chk("R8 finish flag", v & 1, 1);
    chk("R10 finish not enabled", {31'b0, irq}, 0);
    wr(5'h08, 32'h21);
    chk("R10 finish enabled", {31'b0, irq}, 1);
    wr(5'h08, 32'h01);
    chk("R10 global off", {31'b0, irq}, 0);
    wr(5'h0C, 2);
    rd(5'h0C, v); chk("R9 write zero keeps flag", v & 1, 1);
    @(negedge clk); we = 1'b1; addr = 5'h0C; wdata = 1; fin = 1'b1;
    @(negedge clk); we = 1'b0; fin = 1'b0;
    rd(5'h0C, v); chk("R8 finish set wins", v & 1, 1);
    wr(5'h0C, 1);
    rd(5'h0C, v); chk("R9 finish cleared", v & 1, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R11 int ctrl bits", v, 32'h23);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R11 dma ctrl bits", v, 32'h27);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_full();
    t_dma();
    t_cpu();
    t_finish();
    t_readback();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule